// File: doc/BRIEF.md
# Mantissa normalizer with exponent correction

This block takes an unsigned mantissa and an unsigned exponent and returns the normalized form. The mantissa is shifted left until its most significant set bit sits in the top bit position, and the exponent is lowered by the same number of places. The shift count is also presented as an output, because exponent logic further down the datapath often needs it.

The count is produced in three steps. A one-hot leading-one detector marks the top set bit. A priority encoder turns that mark into a count measured from the MSB, so the count is the number of left shifts needed. A logarithmic barrel shifter then applies the count, and a subtractor applies it to the exponent.

An all-zero mantissa raises a zero flag and leaves the exponent untouched. If the correction would take the exponent below zero, an underflow flag is raised. The datapath is purely combinational. The parameter `REG_OUT` adds one register stage on every output.

Top module: `mant_norm`

## Requirements
- R1: For a nonzero mantissa, `shift_o` equals MANT_W-1 minus the bit index of the most significant 1 of `mant_i`. Bit MANT_W-1 is the MSB.
- R2: For a nonzero mantissa, `mant_o` equals `mant_i` shifted left by `shift_o`, truncated to MANT_W bits. Its MSB is 1.
- R3: The `shift_o` low bits of `mant_o` that the shift vacates are 0.
- R4: For a nonzero mantissa, `exp_o` equals `exp_i - shift_o`, taken modulo 2^EXP_W.
- R5: `uflow_o` is 1 exactly when the mantissa is nonzero and `exp_i < shift_o`.
- R6: When `mant_i` is all zero, the outputs are: `zero_o`=1, `mant_o`=0, `shift_o`=0, `exp_o`=`exp_i` and `uflow_o`=0. When `mant_i` is nonzero, `zero_o`=0.
- R7: A mantissa whose MSB is already 1 gives `shift_o`=0, `mant_o`=`mant_i` and `exp_o`=`exp_i`.
- R8: With REG_OUT=1, each output reflects the inputs sampled at the previous rising edge of `clk_i`. With REG_OUT=0, the outputs follow the inputs within the same cycle.
- R9: With REG_OUT=1, while `rst_ni` is low the outputs are: `mant_o`, `shift_o`, `exp_o` and `uflow_o` all 0, and `zero_o` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mant_i | input | MANT_W | Unsigned mantissa to normalize |
| exp_i | input | EXP_W | Unsigned exponent to correct |
| mant_o | output | MANT_W | Normalized mantissa |
| shift_o | output | $clog2(MANT_W) | Left shift applied |
| exp_o | output | EXP_W | Corrected exponent |
| zero_o | output | 1 | Mantissa was all zero |
| uflow_o | output | 1 | Exponent correction went below zero |

## Verification
The hardest case to reach is the boundary of the underflow flag. It needs an exponent exactly equal to the shift count, and one just below it, for every leading-one position. Random operands rarely hit this pairing.

To reach it, the registered 8-bit configuration is swept over every mantissa crossed with every exponent. That sweep covers each shift count against each exponent, including equality. A 16-bit combinational instance is then driven with a walking leading one plus random lower bits, and an exponent placed right at the count. This exercises every shift amount at full width.

// File: rtl/mant_norm_pkg.sv
package mant_norm_pkg;
  // Width of a shift count able to address every bit of a w-bit word
  function automatic int cnt_w(input int w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/mn_lead_one.sv
module mn_lead_one #(
  parameter int W = 16
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] hot_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign hot_o[i] = vec_i[i];
    end else begin : g_low
      assign hot_o[i] = vec_i[i] & ~(|vec_i[W-1:i+1]);
    end
  end

  always_comb begin
    AST_LOD_ONEHOT: assert ($onehot0(hot_o));  // R1
    AST_LOD_ZERO: assert ((hot_o == '0) == (vec_i == '0));  // R6
  end
endmodule

// File: rtl/mn_prio_enc.sv
module mn_prio_enc #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  hot_i,
  output logic [CW-1:0] cnt_o
);
  // count measured from the MSB: equals the left shift needed
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (hot_i[i]) cnt_o = cnt_o | CW'(W - 1 - i);
    end
  end

  always_comb begin
    AST_ENC_MSB_ZERO: assert (!hot_i[W-1] || cnt_o == '0);  // R7
  end
endmodule

// File: rtl/mn_lshift.sv
module mn_lshift #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic [W-1:0]  data_i,
  input  logic [CW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [CW:0][W-1:0] stg;

  assign stg[0] = data_i;
  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? (stg[k] << STEP) : stg[k];
  end
  assign data_o = stg[CW];

  always_comb begin
    AST_FILL_ZERO: assert ((data_o & ~({W{1'b1}} << amt_i)) == '0);  // R3
  end
endmodule

// File: rtl/mant_norm.sv
module mant_norm
  import mant_norm_pkg::*;
#(
  parameter int MANT_W  = 16,
  parameter int EXP_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [MANT_W-1:0]         mant_i,
  input  logic [EXP_W-1:0]          exp_i,
  output logic [MANT_W-1:0]         mant_o,
  output logic [cnt_w(MANT_W)-1:0]  shift_o,
  output logic [EXP_W-1:0]          exp_o,
  output logic                      zero_o,
  output logic                      uflow_o
);
  localparam int CW = cnt_w(MANT_W);

  logic [MANT_W-1:0] hot;
  logic [CW-1:0]     amt;
  logic [MANT_W-1:0] norm;
  logic [EXP_W:0]    diff;
  logic              zero_c;

  mn_lead_one #(.W(MANT_W)) u_lod (
    .vec_i (mant_i),
    .hot_o (hot)
  );

  mn_prio_enc #(.W(MANT_W), .CW(CW)) u_enc (
    .hot_i (hot),
    .cnt_o (amt)
  );

  mn_lshift #(.W(MANT_W), .CW(CW)) u_shf (
    .data_i (mant_i),
    .amt_i  (amt),
    .data_o (norm)
  );

  assign zero_c = (hot == '0);
  // one guard bit catches the borrow out of the exponent
  assign diff = {1'b0, exp_i} - (EXP_W + 1)'(amt);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mant_o  <= '0;
        shift_o <= '0;
        exp_o   <= '0;
        zero_o  <= 1'b1;
        uflow_o <= 1'b0;
      end else begin
        mant_o  <= norm;
        shift_o <= amt;
        exp_o   <= diff[EXP_W-1:0];
        zero_o  <= zero_c;
        uflow_o <= diff[EXP_W];
      end
    end
  end else begin : g_comb
    assign mant_o  = norm;
    assign shift_o = amt;
    assign exp_o   = diff[EXP_W-1:0];
    assign zero_o  = zero_c;
    assign uflow_o = diff[EXP_W];
  end

  AST_NORM_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_o |-> mant_o[MANT_W-1]);  // R2
  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> (mant_o == '0 && shift_o == '0 && !uflow_o));  // R6
  AST_UFLOW_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |-> (exp_o > ~shift_o || shift_o != '0));  // R5
endmodule

// File: tb/mant_norm_tb_top.sv
module mant_norm_tb_top;
  localparam int MW = 8;
  localparam int EW = 4;
  localparam int SW = 3;
  localparam int MW2 = 16;
  localparam int EW2 = 8;
  localparam int SW2 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [MW-1:0] m_in, m_out;
  logic [EW-1:0] e_in, e_out;
  logic [SW-1:0] s_out;
  logic z_out, u_out;

  logic [MW2-1:0] m2_in, m2_out;
  logic [EW2-1:0] e2_in, e2_out;
  logic [SW2-1:0] s2_out;
  logic z2_out, u2_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  mant_norm #(.MANT_W(MW), .EXP_W(EW), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mant_i(m_in), .exp_i(e_in),
    .mant_o(m_out), .shift_o(s_out), .exp_o(e_out), .zero_o(z_out), .uflow_o(u_out)
  );

  mant_norm #(.MANT_W(MW2), .EXP_W(EW2), .REG_OUT(1'b0)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .mant_i(m2_in), .exp_i(e2_in),
    .mant_o(m2_out), .shift_o(s2_out), .exp_o(e2_out), .zero_o(z2_out), .uflow_o(u2_out)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lead_sh(input longint v, input int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return w - 1 - i;
    return 0;
  endfunction

  // compare one result against the arithmetic model
  task automatic model(input int w, input int ew, input longint mi, input longint ei,
                       input longint mo, input longint so, input longint eo,
                       input longint zo, input longint uo);
    longint msk = (64'd1 << w) - 1;
    longint emsk = (64'd1 << ew) - 1;
    int sh = lead_sh(mi, w);
    if (mi == 0) begin
      chk("R6 zero flag", zo, 1);
      chk("R6 mantissa", mo, 0);
      chk("R6 shift", so, 0);
      chk("R6 exponent", eo, ei);
      chk("R6 uflow", uo, 0);
    end else begin
      chk("R6 zero flag", zo, 0);
      chk("R1 shift", so, sh);
      chk("R2 mantissa", mo, (mi << sh) & msk);
      chk("R2 msb", (mo >> (w - 1)) & 1, 1);
      chk("R3 fill", mo & ((64'd1 << sh) - 1), 0);
      chk("R4 exponent", eo, (ei - sh) & emsk);
      chk("R5 uflow", uo, (ei < sh) ? 1 : 0);
      if (mi[w-1]) begin
        chk("R7 msb set", so, 0);
        chk("R7 passthru", eo, ei);
      end
    end
  endtask

  initial begin
    m_in = 8'hA5; e_in = 4'h3; m2_in = '0; e2_in = '0;
    repeat (3) @(negedge clk);
    // R9 reset state of the registered instance
    chk("R9 mant", m_out, 0);
    chk("R9 shift", s_out, 0);
    chk("R9 exp", e_out, 0);
    chk("R9 zero", z_out, 1);
    chk("R9 uflow", u_out, 0);
    rst_n = 1'b1;
    // R8 registered: result seen one edge later, not before
    @(negedge clk);
    m_in = 8'h01; e_in = 4'h2;
    #1 chk("R8 holds until edge", s_out, 0);
    @(negedge clk);
    chk("R8 one-cycle latency", s_out, 7);
    for (int m = 0; m < (1 << MW); m++) begin
      for (int e = 0; e < (1 << EW); e++) begin
        @(negedge clk);
        m_in = MW'(m); e_in = EW'(e);
        @(negedge clk);
        model(MW, EW, m, e, m_out, s_out, e_out, z_out, u_out);
      end
    end
    // R8 combinational variant: walking lead one, exponent around the count
    for (int p = 0; p < MW2; p++) begin
      for (int d = -1; d <= 1; d++) begin
        int sh = MW2 - 1 - p;
        longint ev = sh + d;
        if (ev < 0) ev = 0;
        m2_in = MW2'((64'd1 << p) | ({$random} & ((64'd1 << p) - 1)));
        e2_in = EW2'(ev);
        #1;
        model(MW2, EW2, m2_in, e2_in, m2_out, s2_out, e2_out, z2_out, u2_out);
      end
    end
    m2_in = '0; e2_in = 8'h7E; #1;
    model(MW2, EW2, m2_in, e2_in, m2_out, s2_out, e2_out, z2_out, u2_out);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule